// File: doc/BRIEF.md
# Integer Multiply-Accumulate Unit

This block is the multiply side of a 32-bit integer datapath. It holds a high and a low accumulator register that together form one double-width accumulator. It offers three multiply forms:

- a full multiply that replaces the accumulator with the whole product;
- a low-half multiply that sends only the lower word of the product to the general-register result port, discards the upper word and leaves the accumulator untouched;
- a multiply-add that adds the product into the accumulator.

Read operations copy either accumulator half onto the result port. Write operations load either half from an operand.

An operation is launched with a one-cycle start strobe, together with an operation code, a signedness select and two operands. Multiply results arrive after a fixed, parameterised latency. While a multiply is in flight, a read of either half is parked and completed one cycle after the multiply finishes, so the read always sees the updated accumulator. Any other request made during that window is dropped.

Top module: `mac_accum_unit`

## Requirements
- R1: After reset, `hi_o`, `lo_o` and `res_o` are zero and `valid_o` is low.
- R2: Operation code 0 (full multiply), sampled at clock edge k while idle, sets {`hi_o`,`lo_o`} to the 2W-bit product. From edge k+MUL_LAT it raises `valid_o` for exactly one cycle, with `res_o` equal to the new low word.
- R3: Operation code 1 (low-half multiply) raises `valid_o` for one cycle from edge k+MUL_LAT with `res_o` equal to the low W bits of the product. `hi_o` and `lo_o` stay unchanged, and the upper product word is stored nowhere.
- R4: Operation code 2 (multiply-add) sets {`hi_o`,`lo_o`} to its previous value plus the product, modulo 2^(2W). A carry out of the low word moves into the high word, and a carry out of the top bit is lost. Its `valid_o` and `res_o` timing matches R2.
- R5: With `sign_i` = 1 both operands are read as two's complement. With `sign_i` = 0 both are read as unsigned.
- R6: Operation codes 3 (read high) and 4 (read low), sampled at edge k while idle, raise `valid_o` for one cycle from edge k, with `res_o` equal to the high or low register. The accumulator is left unchanged.
- R7: Operation codes 5 (write high) and 6 (write low), sampled while idle, load the high or low register from `opa_i` at that edge and do not raise `valid_o`.
- R8: A read (code 3 or 4) sampled while a multiply is in flight, including on the multiply's completion edge, is held. It completes from edge k+MUL_LAT+1, where k is the multiply's sampling edge, and returns the value after that multiply.
- R9: While a multiply is in flight or a held read is waiting, every other request is ignored: multiplies, writes, a second read, and any request on the edge the held read completes. Code 7 never has any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, one cycle per request |
| op_i | input | 3 | Operation code (0..7, see requirements) |
| sign_i | input | 1 | 1 = signed operands, 0 = unsigned |
| opa_i | input | W | First operand; data for register writes |
| opb_i | input | W | Second operand |
| valid_o | output | 1 | One-cycle result strobe |
| res_o | output | W | Result for the general register file |
| hi_o | output | W | High accumulator register |
| lo_o | output | W | Low accumulator register |

## Verification
The hardest situation to reach from the ports is a read that lands inside the multiply window. This is especially so when it lands exactly on the completion edge, when it is followed by further requests while it is still parked, and when a request arrives on the edge the parked read is served. The stimulus reaches these cases by launching a multiply-add and then placing reads and writes a counted number of cycles later, at every offset across the window. A randomised stream with gaps from zero to beyond the latency then mixes all codes. A cycle-stamped scoreboard rejects any result that arrives early, late, or for a request that should have been dropped.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [2:0] {
      OP_MULFULL = 3'd0,
      OP_MULLOW  = 3'd1,
      OP_MULACC  = 3'd2,
      OP_RDHI    = 3'd3,
      OP_RDLO    = 3'd4,
      OP_WRHI    = 3'd5,
      OP_WRLO    = 3'd6,
      OP_NONE    = 3'd7
   } mac_op_e;

   function automatic logic op_is_mul(mac_op_e op);
      return (op == OP_MULFULL) || (op == OP_MULLOW) || (op == OP_MULACC);
   endfunction

   function automatic logic op_is_rd(mac_op_e op);
      return (op == OP_RDHI) || (op == OP_RDLO);
   endfunction

   function automatic logic op_is_wr(mac_op_e op);
      return (op == OP_WRHI) || (op == OP_WRLO);
   endfunction

endpackage

// File: rtl/mac_product.sv
module mac_product #(
   parameter int unsigned W         = 32,
   parameter bit          SIGNED_OK = 1'b1
) (
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   input  logic           sgn_i,
   output logic [2*W-1:0] prod_o
);

   localparam int unsigned PW = 2 * W;

   generate
      if (SIGNED_OK) begin : g_signed
         logic [PW-1:0] ext_a;
         logic [PW-1:0] ext_b;
         assign ext_a  = {{W{sgn_i & a_i[W-1]}}, a_i};
         assign ext_b  = {{W{sgn_i & b_i[W-1]}}, b_i};
         assign prod_o = ext_a * ext_b;
      end else begin : g_unsigned
         logic unused_sgn;
         assign unused_sgn = sgn_i;
         assign prod_o     = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
      end
   endgenerate

endmodule

// File: rtl/mac_pipe.sv
module mac_pipe
   import mac_pkg::*;
#(
   parameter int unsigned PW    = 64,
   parameter int unsigned DEPTH = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          in_v_i,
   input  mac_op_e       in_op_i,
   input  logic [PW-1:0] in_prod_i,
   output logic          out_v_o,
   output mac_op_e       out_op_o,
   output logic [PW-1:0] out_prod_o,
   output logic          busy_o
);

   logic [DEPTH-1:0] v_q;
   mac_op_e          op_q   [DEPTH];
   logic [PW-1:0]    prod_q [DEPTH];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         v_q <= '0;
         for (int s = 0; s < DEPTH; s++) begin
            op_q[s]   <= OP_NONE;
            prod_q[s] <= '0;
         end
      end else begin
         v_q[0] <= in_v_i;
         if (in_v_i) begin
            op_q[0]   <= in_op_i;
            prod_q[0] <= in_prod_i;
         end
         for (int s = 1; s < DEPTH; s++) begin
            v_q[s] <= v_q[s-1];
            if (v_q[s-1]) begin
               op_q[s]   <= op_q[s-1];
               prod_q[s] <= prod_q[s-1];
            end
         end
      end
   end

   assign busy_o     = |v_q;
   assign out_v_o    = v_q[DEPTH-1];
   assign out_op_o   = op_q[DEPTH-1];
   assign out_prod_o = prod_q[DEPTH-1];

endmodule

// File: rtl/mac_seq.sv
module mac_seq
   import mac_pkg::*;
(
   input  logic    clk_i,
   input  logic    rst_ni,
   input  logic    start_i,
   input  mac_op_e op_i,
   input  logic    pipe_busy_i,
   output logic    issue_o,
   output logic    wr_hi_o,
   output logic    wr_lo_o,
   output logic    rd_fire_o,
   output logic    rd_hi_o,
   output logic    idle_o
);

   logic pend_q;
   logic pend_hi_q;
   logic idle;
   logic direct_rd;
   logic park;
   logic serve;

   assign idle      = !pipe_busy_i && !pend_q;
   assign issue_o   = start_i && idle && op_is_mul(op_i);
   assign wr_hi_o   = start_i && idle && (op_i == OP_WRHI);
   assign wr_lo_o   = start_i && idle && (op_i == OP_WRLO);
   assign direct_rd = start_i && idle && op_is_rd(op_i);
   assign park      = start_i && pipe_busy_i && !pend_q && op_is_rd(op_i);
   assign serve     = pend_q && !pipe_busy_i;
   assign rd_fire_o = direct_rd || serve;
   assign rd_hi_o   = pend_q ? pend_hi_q : (op_i == OP_RDHI);
   assign idle_o    = idle;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q    <= 1'b0;
         pend_hi_q <= 1'b0;
      end else begin
         if (park) begin
            pend_q    <= 1'b1;
            pend_hi_q <= (op_i == OP_RDHI);
         end else if (serve) begin
            pend_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mac_acc.sv
module mac_acc
   import mac_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           cm_v_i,
   input  mac_op_e        cm_op_i,
   input  logic [2*W-1:0] cm_prod_i,
   input  logic           wr_hi_i,
   input  logic           wr_lo_i,
   input  logic [W-1:0]   wr_data_i,
   input  logic           rd_fire_i,
   input  logic           rd_hi_i,
   output logic           valid_o,
   output logic [W-1:0]   res_o,
   output logic [W-1:0]   hi_o,
   output logic [W-1:0]   lo_o
);

   localparam int unsigned PW = 2 * W;

   logic [PW-1:0] acc_q, acc_d, acc_sum;
   logic [W-1:0]  res_q, res_d;
   logic          valid_q;

   assign acc_sum = acc_q + cm_prod_i;

   always_comb begin
      acc_d = acc_q;
      if (cm_v_i) begin
         case (cm_op_i)
            OP_MULFULL: acc_d = cm_prod_i;
            OP_MULACC:  acc_d = acc_sum;
            default:    acc_d = acc_q;
         endcase
      end
      if (wr_hi_i) acc_d[PW-1:W] = wr_data_i;
      if (wr_lo_i) acc_d[W-1:0]  = wr_data_i;
   end

   always_comb begin
      res_d = res_q;
      if (cm_v_i) begin
         res_d = (cm_op_i == OP_MULLOW) ? cm_prod_i[W-1:0] : acc_d[W-1:0];
      end else if (rd_fire_i) begin
         res_d = rd_hi_i ? acc_q[PW-1:W] : acc_q[W-1:0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q   <= '0;
         res_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         acc_q   <= acc_d;
         res_q   <= res_d;
         valid_q <= cm_v_i || rd_fire_i;
      end
   end

   assign valid_o = valid_q;
   assign res_o   = res_q;
   assign hi_o    = acc_q[PW-1:W];
   assign lo_o    = acc_q[W-1:0];

endmodule

// File: rtl/mac_accum_unit.sv
module mac_accum_unit
   import mac_pkg::*;
#(
   parameter int unsigned W         = 32,
   parameter int unsigned MUL_LAT   = 3,
   parameter bit          SIGNED_OK = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic [2:0]   op_i,
   input  logic         sign_i,
   input  logic [W-1:0] opa_i,
   input  logic [W-1:0] opb_i,
   output logic         valid_o,
   output logic [W-1:0] res_o,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o
);

   localparam int unsigned PW = 2 * W;

   generate
      if (W < 2) begin : g_bad_width
         $error("mac_accum_unit: W must be at least 2");
      end
      if (MUL_LAT < 1) begin : g_bad_lat
         $error("mac_accum_unit: MUL_LAT must be at least 1");
      end
   endgenerate

   mac_op_e       op_e;
   logic [PW-1:0] prod;
   logic          issue, wr_hi, wr_lo, rd_fire, rd_hi, seq_idle;
   logic          pipe_busy, cm_v;
   mac_op_e       cm_op;
   logic [PW-1:0] cm_prod;

   assign op_e = mac_op_e'(op_i);

   mac_product #(.W(W), .SIGNED_OK(SIGNED_OK)) u_prod (
      .a_i    (opa_i),
      .b_i    (opb_i),
      .sgn_i  (sign_i),
      .prod_o (prod)
   );

   mac_seq u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .op_i        (op_e),
      .pipe_busy_i (pipe_busy),
      .issue_o     (issue),
      .wr_hi_o     (wr_hi),
      .wr_lo_o     (wr_lo),
      .rd_fire_o   (rd_fire),
      .rd_hi_o     (rd_hi),
      .idle_o      (seq_idle)
   );

   mac_pipe #(.PW(PW), .DEPTH(MUL_LAT)) u_pipe (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_v_i     (issue),
      .in_op_i    (op_e),
      .in_prod_i  (prod),
      .out_v_o    (cm_v),
      .out_op_o   (cm_op),
      .out_prod_o (cm_prod),
      .busy_o     (pipe_busy)
   );

   mac_acc #(.W(W)) u_acc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cm_v_i    (cm_v),
      .cm_op_i   (cm_op),
      .cm_prod_i (cm_prod),
      .wr_hi_i   (wr_hi),
      .wr_lo_i   (wr_lo),
      .wr_data_i (opa_i),
      .rd_fire_i (rd_fire),
      .rd_hi_i   (rd_hi),
      .valid_o   (valid_o),
      .res_o     (res_o),
      .hi_o      (hi_o),
      .lo_o      (lo_o)
   );

endmodule

// File: rtl/mac_accum_unit_chk.sv
module mac_accum_unit_chk #(
   parameter int unsigned W = 32
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic           start_i,
   input logic [2:0]     op_i,
   input logic           idle_i,
   input logic           pipe_busy_i,
   input logic           cm_v_i,
   input logic [2:0]     cm_op_i,
   input logic [2*W-1:0] cm_prod_i,
   input logic           valid_i,
   input logic [W-1:0]   res_i,
   input logic [W-1:0]   hi_i,
   input logic [W-1:0]   lo_i
);

   a_r2_full_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cm_v_i && cm_op_i == 3'd0) |=> (valid_i && {hi_i, lo_i} == $past(cm_prod_i)));

   a_r3_low_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cm_v_i && cm_op_i == 3'd1) |=>
         (valid_i && res_i == $past(cm_prod_i[W-1:0]) && $stable(hi_i) && $stable(lo_i)));

   a_r4_accumulate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cm_v_i && cm_op_i == 3'd2) |=>
         ({hi_i, lo_i} == $past({hi_i, lo_i}) + $past(cm_prod_i)));

   a_r6_read_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && idle_i && op_i == 3'd4) |=>
         (valid_i && res_i == $past(lo_i) && $stable(hi_i) && $stable(lo_i)));

   a_r7_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && idle_i && (op_i == 3'd5 || op_i == 3'd6)) |=> !valid_i);

   a_r9_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && pipe_busy_i && !cm_v_i && (op_i == 3'd5 || op_i == 3'd6)) |=>
         ($stable(hi_i) && $stable(lo_i)));

endmodule

bind mac_accum_unit mac_accum_unit_chk #(.W(W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .start_i     (start_i),
   .op_i        (op_i),
   .idle_i      (seq_idle),
   .pipe_busy_i (pipe_busy),
   .cm_v_i      (cm_v),
   .cm_op_i     (cm_op),
   .cm_prod_i   (cm_prod),
   .valid_i     (valid_o),
   .res_i       (res_o),
   .hi_i        (hi_o),
   .lo_i        (lo_o)
);

// File: tb/mac_accum_unit_tb_top.sv
module mac_accum_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;
   localparam int WD_CYCLES  = 20000;

   typedef struct {
      logic [31:0] res;
      int          cyc;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op_in = 3'd7;
   logic        sgn = 1'b0;
   logic [31:0] opa = '0, opb = '0;
   logic        valid_o;
   logic [31:0] res_o, hi_o, lo_o;

   int          cyc = 0;
   int          checks = 0;
   int          errs = 0;
   exp_t        sb_q[$];
   exp_t        mon_item;
   logic [31:0] mhi = '0, mlo = '0;
   int          mul_k = -1000;
   int          pend_set = -1000;
   int          pend_srv = -1000;

   mac_accum_unit #(.W(32), .MUL_LAT(LAT), .SIGNED_OK(1'b1)) dut_i (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .start_i (start),
      .op_i    (op_in),
      .sign_i  (sgn),
      .opa_i   (opa),
      .opb_i   (opb),
      .valid_o (valid_o),
      .res_o   (res_o),
      .hi_o    (hi_o),
      .lo_o    (lo_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic push(logic [31:0] r, int c, string tag);
      exp_t it;
      it.res = r; it.cyc = c; it.tag = tag;
      sb_q.push_back(it);
   endtask

   // monitor: compares each result strobe against the scoreboard head
   always @(negedge clk) begin
      if (rst_n) begin
         if (valid_o) begin
            checks++;
            if (sb_q.size() == 0) begin
               errs++;
               $display("FAIL R9 unexpected result act=%h exp=none", res_o);
            end else begin
               mon_item = sb_q.pop_front();
               if (res_o !== mon_item.res || cyc != mon_item.cyc) begin
                  errs++;
                  $display("FAIL %s act=%h@%0d exp=%h@%0d", mon_item.tag,
                           res_o, cyc, mon_item.res, mon_item.cyc);
               end
            end
         end else if (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
            checks++;
            errs++;
            mon_item = sb_q.pop_front();
            $display("FAIL %s act=none@%0d exp=%h@%0d", mon_item.tag, cyc,
                     mon_item.res, mon_item.cyc);
         end
      end
   end

   // driver: drives one request and predicts its outcome
   task automatic issue(logic [2:0] op, logic sg, logic [31:0] a, logic [31:0] b, string tag);
      int          e;
      logic        pb, pd;
      logic [63:0] ea, eb, prod;
      @(negedge clk);
      start = 1'b1; op_in = op; sgn = sg; opa = a; opb = b;
      e  = cyc + 1;
      pb = (e >= mul_k + 1) && (e <= mul_k + LAT);
      pd = (e > pend_set) && (e <= pend_srv);
      ea = sg ? {{32{a[31]}}, a} : {32'b0, a};
      eb = sg ? {{32{b[31]}}, b} : {32'b0, b};
      prod = ea * eb;
      if (!pb && !pd) begin
         case (op)
            3'd0: begin {mhi, mlo} = prod; push(mlo, e + LAT, tag); mul_k = e; end
            3'd1: begin push(prod[31:0], e + LAT, tag); mul_k = e; end
            3'd2: begin {mhi, mlo} = {mhi, mlo} + prod; push(mlo, e + LAT, tag); mul_k = e; end
            3'd3: push(mhi, e, tag);
            3'd4: push(mlo, e, tag);
            3'd5: mhi = a;
            3'd6: mlo = a;
            default: ;
         endcase
      end else if (pb && !pd && (op == 3'd3 || op == 3'd4)) begin
         push((op == 3'd3) ? mhi : mlo, mul_k + LAT + 1, tag);
         pend_set = e;
         pend_srv = mul_k + LAT + 1;
      end
   endtask

   task automatic gap(int n);
      @(negedge clk);
      start = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic check_acc(string tag);
      gap(LAT + 3);
      chk(tag, {hi_o, lo_o}, {mhi, mlo});
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog act=running exp=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 valid", {63'b0, valid_o}, 64'd0);
      chk("R1 res", {32'b0, res_o}, 64'd0);
      chk("R1 acc", {hi_o, lo_o}, 64'd0);
      rst_n = 1'b1;
      gap(2);

      // R7: writes load each half, no result strobe
      issue(3'd5, 1'b0, 32'h1234_5678, 32'h0, "R7");
      issue(3'd6, 1'b0, 32'h9abc_def0, 32'h0, "R7");
      check_acc("R7 writes");

      // R6: reads back to back
      issue(3'd3, 1'b0, 32'h0, 32'h0, "R6 read hi");
      issue(3'd4, 1'b0, 32'h0, 32'h0, "R6 read lo");
      check_acc("R6 acc unchanged");

      // R2/R5: unsigned full multiply
      issue(3'd0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 full unsigned");
      check_acc("R2 R5 unsigned product");
      chk("R2 value", {hi_o, lo_o}, 64'hFFFF_FFFE_0000_0001);

      // R5: signed full multiply
      issue(3'd0, 1'b1, 32'hFFFF_FFFD, 32'd5, "R5 signed");
      check_acc("R5 signed product");
      chk("R5 value", {hi_o, lo_o}, 64'hFFFF_FFFF_FFFF_FFF1);

      // R3: low-half multiply leaves accumulator
      issue(3'd1, 1'b1, 32'hFFFF_FFF9, 32'd9, "R3 low half");
      check_acc("R3 acc unchanged");
      chk("R3 value", {hi_o, lo_o}, 64'hFFFF_FFFF_FFFF_FFF1);

      // R4: carry from low into high
      issue(3'd6, 1'b0, 32'hFFFF_FFFF, 32'h0, "R7");
      issue(3'd5, 1'b0, 32'h0, 32'h0, "R7");
      issue(3'd2, 1'b0, 32'd1, 32'd1, "R4 carry");
      check_acc("R4 carry");
      chk("R4 carry value", {hi_o, lo_o}, 64'h0000_0001_0000_0000);

      // R4: wrap beyond the top bit
      issue(3'd5, 1'b0, 32'hFFFF_FFFF, 32'h0, "R7");
      issue(3'd6, 1'b0, 32'hFFFF_FFFF, 32'h0, "R7");
      issue(3'd2, 1'b0, 32'd1, 32'd1, "R4 wrap");
      check_acc("R4 wrap");
      chk("R4 wrap value", {hi_o, lo_o}, 64'd0);

      // R4/R5: signed multiply-add of a negative product
      issue(3'd2, 1'b1, 32'hFFFF_FFFE, 32'd3, "R4 signed acc");
      issue(3'd0, 1'b0, 32'h0, 32'h0, "R9 dropped mul");
      check_acc("R4 R5 signed acc");
      chk("R4 signed value", {hi_o, lo_o}, 64'hFFFF_FFFF_FFFF_FFFA);

      // R8/R9: read parked during multiply; further requests dropped
      issue(3'd2, 1'b0, 32'h0001_0000, 32'h0001_0000, "R8 madd");
      issue(3'd3, 1'b0, 32'h0, 32'h0, "R8 parked read");
      issue(3'd4, 1'b0, 32'h0, 32'h0, "R9 second read");
      issue(3'd5, 1'b0, 32'hDEAD_BEEF, 32'h0, "R9 write");
      issue(3'd6, 1'b0, 32'hDEAD_BEEF, 32'h0, "R9 write");
      check_acc("R9 busy requests ignored");

      // R8: read on the completion edge, then request on the serve edge
      for (int off = 1; off <= LAT + 2; off++) begin
         issue(3'd2, 1'b1, 32'hFFFF_0003, 32'h0000_7001, "R8 madd");
         if (off > 1) gap(off - 1);
         issue(3'd4, 1'b0, 32'h0, 32'h0, "R8 offset read");
         issue(3'd5, 1'b0, 32'h0BAD_0BAD, 32'h0, "R9 serve-edge write");
         check_acc("R8 R9 window");
      end

      // R9: code 7 has no effect
      issue(3'd7, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 code7");
      check_acc("R9 code 7 idle");

      // mixed stream
      for (int i = 0; i < 80; i++) begin
         issue(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
               $urandom(), $urandom(), "R2 R3 R4 R6 R8 mixed");
         if ($urandom_range(0, 2) == 0) gap($urandom_range(1, LAT + 2));
      end
      check_acc("R2 R4 R7 mixed acc");
      gap(4);
      chk("R8 scoreboard drained", 64'(sb_q.size()), 64'd0);
      finish_run();
   end

endmodule